// File: doc/BRIEF.md
# Transport Packet PID Channel Mapper

This block sits behind a set of transport-stream parser bands and decides, packet by packet, which logical channel a 188-byte MPEG transport packet belongs to. Bytes arrive on one valid/ready stream together with the index of the band they came from. The first three bytes of each packet are collected. The 13-bit packet identifier is then compared in parallel against every entry of a small mapping table. A packet that hits an entry is replayed unchanged on the output stream, and every byte carries that entry's channel number. A packet that hits nothing is consumed and discarded.

Each table entry names one band, a primary identifier, an optional secondary identifier and a target channel. An identifier is therefore recognised only on the band its entry names, and two identifiers can be folded onto one channel. Channels below 128 are the ones allowed onward to the section/message filtering path, and a separate output flag marks them. The table is programmed through a plain write port. A write made while a packet is being handled lands in a shadow copy, and the lookup copy is refreshed only between packets.

Back-pressure: the input is accepted freely while the header is being collected and while a rejected packet is being discarded. While header bytes are being replayed, the input is held off. For the rest of a kept packet, the input ready follows the output ready directly, so a stalled consumer stalls the producer with no extra buffering. A byte offered on the output stays offered, with the same data, until it is taken.

Top module: `pid_chan_mapper`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and every table entry is disabled.
- R2: A packet whose band and PID (PID = byte 1 bits 4:0 followed by byte 2) hit an enabled entry is emitted as all 188 bytes, unchanged and in order. `out_sop` is high only on byte 0, `out_eop` only on byte 187, and `out_chan` equals the entry's channel on every byte.
- R3: An entry matches only packets from the band it names, so one PID on two bands can go to two different channels, or be dropped on a band with no entry.
- R4: When an entry's secondary-enable bit is set, a packet carrying the secondary PID goes to the same channel as one carrying the primary PID.
- R5: A packet that hits no entry produces no output byte at all. A band index of NUM_BANDS or above never matches, even when an entry names it.
- R6: A packet whose byte 0 is not 0x47 is dropped even if its PID matches.
- R7: When several enabled entries match, the channel of the lowest-indexed one is used.
- R8: `out_msg` is high exactly when `out_chan` is below 128.
- R9: A table write accepted after byte 0 of a packet has been taken has no effect on that packet and applies from the next packet on.
- R10: While `out_ready` is low, `out_valid` stays high and `out_data` is unchanged, and no byte is lost or repeated.
- R11: An entry whose enable bit is clear matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input packet byte |
| in_band | input | 3 | Parser band of the packet, sampled on byte 0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Output packet byte |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| out_chan | output | 8 | Channel tag of the packet |
| out_msg | output | 1 | Channel is eligible for message filtering |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_band | input | 3 | Band the entry is bound to |
| cfg_pid | input | 13 | Primary PID |
| cfg_sec_en | input | 1 | Secondary PID enable |
| cfg_sec_pid | input | 13 | Secondary PID |
| cfg_chan | input | 8 | Target channel |

## Verification
The bench builds the block with its default parameters: six bands, sixteen entries and 188-byte packets. With six bands, a 3-bit band field can still carry index 6, so the out-of-range band case can be reached. The table is loaded so that two entries collide on one band and PID, one PID appears on three bands, and two channels sit either side of 128. Priority, band binding and the message-flag boundary all show at the ports. A mid-packet rewrite of a live entry and a toggling consumer exercise the shadow-table boundary and the stall path.

// File: rtl/pidmap_pkg.sv
package pidmap_pkg;
  localparam int PID_W  = 13;
  localparam int CH_W   = 8;
  localparam int BAND_W = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef struct packed {
    logic              en;
    logic [BAND_W-1:0] band;
    logic [PID_W-1:0]  pid;
    logic              sec_en;
    logic [PID_W-1:0]  sec_pid;
    logic [CH_W-1:0]   chan;
  } map_entry_t;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_EMIT,
    ST_PASS,
    ST_DROP
  } phase_e;
endpackage

// File: rtl/pidmap_table.sv
module pidmap_table import pidmap_pkg::*; #(
  parameter int NUM_ENTRIES = 16,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IW-1:0]                wr_idx,
  input  map_entry_t                   wr_entry,
  input  logic                         commit,
  output map_entry_t [NUM_ENTRIES-1:0] act_o
);
  map_entry_t [NUM_ENTRIES-1:0] shadow_q;
  map_entry_t [NUM_ENTRIES-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q[wr_idx] <= wr_entry;
      if (commit) active_q <= shadow_q;
    end
  end

  assign act_o = active_q;

  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));
endmodule

// File: rtl/pidmap_match.sv
module pidmap_match import pidmap_pkg::*; #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_BANDS   = 6,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  map_entry_t [NUM_ENTRIES-1:0] tbl,
  input  logic [BAND_W-1:0]            band,
  input  logic [PID_W-1:0]             pid,
  output logic                         hit,
  output logic [CH_W-1:0]              chan
);
  logic                   band_ok;
  logic [NUM_ENTRIES-1:0] hits;
  logic [IW-1:0]          sel;

  assign band_ok = (32'(band) < NUM_BANDS);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hits[g] = band_ok && tbl[g].en && (tbl[g].band == band) &&
                     ((tbl[g].pid == pid) || (tbl[g].sec_en && (tbl[g].sec_pid == pid)));
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) sel = IW'(i);
    end
  end

  assign hit  = |hits;
  assign chan = tbl[sel].chan;

  always_comb begin
    if (hit) begin
      // R7
      prio_chk: assert (hits[sel] &&
        ((hits & ((NUM_ENTRIES'(1) << sel) - NUM_ENTRIES'(1))) == '0));
    end
  end
endmodule

// File: rtl/pidmap_ctrl.sv
module pidmap_ctrl import pidmap_pkg::*; #(
  parameter int PKT_BYTES = 188,
  localparam int CW = $clog2(PKT_BYTES),
  localparam logic [CW-1:0] LAST = CW'(PKT_BYTES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [BAND_W-1:0] in_band,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CH_W-1:0]   out_chan,
  output logic [BAND_W-1:0] lk_band,
  output logic [PID_W-1:0]  lk_pid,
  input  logic              lk_hit,
  input  logic [CH_W-1:0]   lk_chan,
  output logic              commit
);
  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [1:0]        ecnt_q;
  logic [7:0]        h0_q, h1_q, h2_q;
  logic [BAND_W-1:0] band_q;
  logic [CH_W-1:0]   chan_q;
  logic              in_fire, out_fire;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    unique case (phase_q)
      ST_HDR:  in_ready = 1'b1;
      ST_EMIT: begin
        out_valid = 1'b1;
        case (ecnt_q)
          2'd0:    out_data = h0_q;
          2'd1:    out_data = h1_q;
          default: out_data = h2_q;
        endcase
      end
      ST_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
      end
      ST_DROP: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign lk_band  = band_q;
  assign lk_pid   = {h1_q[4:0], in_data};
  assign commit   = (phase_q == ST_HDR) && (cnt_q == '0);
  assign out_sop  = (phase_q == ST_EMIT) && (ecnt_q == 2'd0);
  assign out_eop  = (phase_q == ST_PASS) && (cnt_q == LAST);
  assign out_chan = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_HDR;
      cnt_q   <= '0;
      ecnt_q  <= '0;
      h0_q    <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      band_q  <= '0;
      chan_q  <= '0;
    end else begin
      unique case (phase_q)
        ST_HDR: if (in_fire) begin
          cnt_q <= cnt_q + 1'b1;
          case (cnt_q[1:0])
            2'd0: begin h0_q <= in_data; band_q <= in_band; end
            2'd1: h1_q <= in_data;
            default: begin
              h2_q <= in_data;
              if ((h0_q == SYNC_BYTE) && lk_hit) begin
                phase_q <= ST_EMIT;
                chan_q  <= lk_chan;
                ecnt_q  <= '0;
              end else begin
                phase_q <= ST_DROP;
              end
            end
          endcase
        end
        ST_EMIT: if (out_fire) begin
          ecnt_q <= ecnt_q + 1'b1;
          if (ecnt_q == 2'd2) phase_q <= ST_PASS;
        end
        ST_PASS, ST_DROP: if (in_fire) begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ST_HDR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= ST_HDR;
      endcase
    end
  end

  // R6
  sync_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_data == SYNC_BYTE));

  // R10
  emit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == ST_EMIT) && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  eop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> !out_valid);

  // R2
  chan_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $stable(out_chan));
endmodule

// File: rtl/pid_chan_mapper.sv
module pid_chan_mapper import pidmap_pkg::*; #(
  parameter int NUM_BANDS   = 6,
  parameter int NUM_ENTRIES = 16,
  parameter int PKT_BYTES   = 188,
  parameter int MSG_CHANS   = 128,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [BAND_W-1:0] in_band,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_msg,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic              cfg_en,
  input  logic [BAND_W-1:0] cfg_band,
  input  logic [PID_W-1:0]  cfg_pid,
  input  logic              cfg_sec_en,
  input  logic [PID_W-1:0]  cfg_sec_pid,
  input  logic [CH_W-1:0]   cfg_chan
);
  map_entry_t                   wr_entry;
  map_entry_t [NUM_ENTRIES-1:0] act;
  logic                         commit;
  logic [BAND_W-1:0]            lk_band;
  logic [PID_W-1:0]             lk_pid;
  logic                         lk_hit;
  logic [CH_W-1:0]              lk_chan;

  assign wr_entry = '{en: cfg_en, band: cfg_band, pid: cfg_pid,
                      sec_en: cfg_sec_en, sec_pid: cfg_sec_pid, chan: cfg_chan};

  pidmap_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_entry(wr_entry), .commit(commit), .act_o(act)
  );

  pidmap_match #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_BANDS(NUM_BANDS)) u_match (
    .tbl(act), .band(lk_band), .pid(lk_pid), .hit(lk_hit), .chan(lk_chan)
  );

  pidmap_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_band(in_band),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_chan(out_chan),
    .lk_band(lk_band), .lk_pid(lk_pid), .lk_hit(lk_hit), .lk_chan(lk_chan),
    .commit(commit)
  );

  assign out_msg = (32'(out_chan) < MSG_CHANS);
endmodule

// File: tb/pid_chan_mapper_bench.sv
module pid_chan_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 188;
  localparam int NV  = 13;
  // {band, sync_ok, keep, pid[15:0], pad, chan[7:0]}
  localparam logic [39:0] VEC [NV] = '{
    40'h0_1_1_0100_0_05, 40'h1_1_1_0100_0_C8, 40'h2_1_0_0100_0_00,
    40'h2_1_1_0020_0_09, 40'h2_1_1_0021_0_09, 40'h0_1_1_00AA_0_82,
    40'h3_1_0_0055_0_00, 40'h0_0_0_0100_0_00, 40'h5_1_0_1234_0_00,
    40'h4_1_1_007F_0_7F, 40'h4_1_1_0080_0_80, 40'h6_1_0_0100_0_00,
    40'h0_1_1_0100_0_05
  };
  string VTAG [NV] = '{"R2", "R3", "R3", "R4", "R4", "R7", "R11", "R6", "R5",
                       "R8", "R8", "R5", "R2"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_band = '0;
  logic out_valid, out_ready = 1'b1, out_sop, out_eop, out_msg;
  logic [7:0] out_data, out_chan;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_sec_en = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [2:0] cfg_band = '0;
  logic [12:0] cfg_pid = '0, cfg_sec_pid = '0;
  logic [7:0] cfg_chan = '0;

  int checks = 0, fails = 0, tot = 0, stall_bad = 0;
  bit done = 1'b0;
  logic [7:0] rx_d [512];
  logic [7:0] rx_c [512];
  logic rx_m [512];
  logic rx_s [512];
  logic rx_e [512];
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_chan_mapper u_pid_chan_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_band(in_band), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_chan(out_chan),
    .out_msg(out_msg), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_band(cfg_band), .cfg_pid(cfg_pid), .cfg_sec_en(cfg_sec_en),
    .cfg_sec_pid(cfg_sec_pid), .cfg_chan(cfg_chan)
  );

  // output monitor, sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        rx_d[tot % 512] = out_data;
        rx_c[tot % 512] = out_chan;
        rx_m[tot % 512] = out_msg;
        rx_s[tot % 512] = out_sop;
        rx_e[tot % 512] = out_eop;
        tot++;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, logic [12:0] pid, bit sync, int seed);
    if (k == 0) return sync ? 8'h47 : 8'h46;
    if (k == 1) return {3'b010, pid[12:8]};
    if (k == 2) return pid[7:0];
    return 8'((k * 7 + seed * 13) & 255);
  endfunction

  task automatic cfg_write(int idx, bit en, int band, int pid, bit sen, int spid, int ch);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_band = 3'(band);
    cfg_pid = 13'(pid); cfg_sec_en = sen; cfg_sec_pid = 13'(spid); cfg_chan = 8'(ch);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send_pkt(int band, logic [12:0] pid, bit sync, int seed);
    for (int k = 0; k < PKT; k++) begin
      bit hs;
      in_valid = 1'b1; in_band = 3'(band); in_data = exp_byte(k, pid, sync, seed);
      do begin
        @(negedge clk); hs = in_ready;
        @(posedge clk); #1;
      end while (!hs);
    end
    in_valid = 1'b0;
  endtask

  task automatic verify(int base, bit keep, logic [7:0] ch, logic [12:0] pid, bit sync,
                        int seed, string tag);
    int n;
    int bad_d, bad_c, bad_m, bad_f, gd, ed;
    repeat (4) @(posedge clk);
    #1;
    n = tot - base;
    if (!keep) begin
      check(n == 0, tag, "bytes emitted for dropped packet", n, 0);
      return;
    end
    check(n == PKT, tag, "byte count", n, PKT);
    bad_d = 0; bad_c = 0; bad_m = 0; bad_f = 0; gd = 0; ed = 0;
    for (int j = 0; j < PKT && j < n; j++) begin
      int ix;
      ix = (base + j) % 512;
      if (rx_d[ix] != exp_byte(j, pid, sync, seed) && bad_d == 0) begin
        bad_d = 1; gd = rx_d[ix]; ed = exp_byte(j, pid, sync, seed);
      end
      if (rx_c[ix] != ch) bad_c++;
      if (rx_m[ix] != (ch < 8'd128)) bad_m++;
      if (rx_s[ix] != (j == 0) || rx_e[ix] != (j == PKT - 1)) bad_f++;
    end
    check(bad_d == 0, tag, "first differing data byte (R2)", gd, ed);
    check(bad_c == 0, tag, "bytes with wrong channel (R2)", bad_c, 0);
    check(bad_m == 0, tag, "bytes with wrong message flag (R8)", bad_m, 0);
    check(bad_f == 0, tag, "bytes with wrong sop/eop (R2)", bad_f, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    // R1: empty table drops everything
    base = tot;
    send_pkt(0, 13'h100, 1'b1, 99);
    verify(base, 1'b0, 8'd0, 13'h100, 1'b1, 99, "R1");

    cfg_write(0, 1, 0, 'h100, 0, 0, 5);
    cfg_write(1, 1, 1, 'h100, 0, 0, 200);
    cfg_write(2, 1, 2, 'h020, 1, 'h021, 9);
    cfg_write(3, 1, 0, 'h0AA, 0, 0, 130);
    cfg_write(4, 1, 0, 'h0AA, 0, 0, 7);
    cfg_write(5, 0, 3, 'h055, 0, 0, 11);   // R11: disabled
    cfg_write(6, 1, 4, 'h07F, 0, 0, 127);
    cfg_write(7, 1, 4, 'h080, 0, 0, 128);
    cfg_write(8, 1, 6, 'h100, 0, 0, 3);    // R5: band out of range
    repeat (2) @(posedge clk);
    #1;

    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      base = tot;
      send_pkt(int'(e[39:36]), e[24:12], e[32], v);
      verify(base, e[28], e[7:0], e[24:12], e[32], v, VTAG[v]);
    end

    // R9: rewrite entry 0 in the middle of a matching packet
    base = tot;
    fork
      send_pkt(0, 13'h100, 1'b1, 20);
      begin repeat (30) @(posedge clk); #1; cfg_write(0, 1, 0, 'h100, 0, 0, 77); end
    join
    verify(base, 1'b1, 8'd5, 13'h100, 1'b1, 20, "R9");
    base = tot;
    send_pkt(0, 13'h100, 1'b1, 21);
    verify(base, 1'b1, 8'd77, 13'h100, 1'b1, 21, "R9");

    // R10: consumer toggles ready
    base = tot;
    fork
      send_pkt(1, 13'h100, 1'b1, 22);
      begin
        for (int t = 0; t < 500; t++) begin
          out_ready = (t % 3) == 0;
          @(posedge clk); #1;
        end
        out_ready = 1'b1;
      end
    join
    verify(base, 1'b1, 8'd200, 13'h100, 1'b1, 22, "R10");
    check(stall_bad == 0, "R10", "stalled bytes that changed", stall_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule